// File: doc/BRIEF.md
# ASCII Hex Frame Receiver with Longitudinal Check

This block sits after a UART receiver. It turns a stream of 7-bit characters into decoded request frames for a serial field-bus slave that uses the printable hex framing. A frame opens with a colon. Pairs of hex characters then carry one byte each, high nibble first. A carriage return followed by a line feed closes the frame.

The block keeps a running 8-bit sum of every decoded byte, so the final check byte can be verified without storing the frame. The first byte is taken as the slave address. Frames whose address is neither the broadcast value 0 nor the configured own address are dropped without any output.

Accepted bytes are streamed out on a one-cycle valid strobe. The check byte itself is never presented, and the last payload byte is marked. A one-cycle done pulse with a good/bad verdict follows the end of each accepted frame. The command layer that uses this output acts only on frames reported good.

Top module: `ascii_frame_rx`

## Requirements
- R1: Characters received while no frame is open are ignored. A frame opens only on a colon (0x3A).
- R2: Inside a frame, each pair of hex characters forms one byte, first character as the high nibble. The characters 0-9, A-F and a-f are hex, and lower-case letters decode like upper-case ones. Any other character except colon and CR is skipped and does not take part in the check.
- R3: A frame is reported good only if the 8-bit sum of all its bytes, including the trailing check byte and with carries dropped, is zero. For example, bytes 02 01 00 00 00 08 followed by check byte F5 is good, and the same bytes followed by F4 is bad.
- R4: A CR (0x0D) moves the frame into its end state. A following LF (0x0A) closes it, and frame_done pulses for one cycle in the cycle after the LF strobe. frame_good is only ever high together with frame_done.
- R5: Every byte except the final check byte is presented in order with a one-cycle byte_valid. byte_last marks the final payload byte and is emitted in the cycle after the CR strobe.
- R6: If the first byte is neither 0 nor own_addr, the frame produces no byte_valid and no frame_done. A frame that ends before any complete byte is also dropped silently.
- R7: A character strobe with char_err high inside a frame is discarded, and that frame is reported bad when it ends.
- R8: A colon inside a frame discards the partial frame and starts a new one with a cleared sum.
- R9: A frame with an odd number of hex characters before CR is reported bad.
- R10: A frame with fewer than two bytes (address plus check byte) is reported bad.
- R11: After CR, any error-free character other than LF or colon ends the frame at once with a bad verdict.
- R12: After reset, byte_valid, byte_last, frame_done and frame_good are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 8 | Address this slave answers to |
| char_valid | input | 1 | One-cycle strobe for a received character |
| char_data | input | 7 | Received character |
| char_err | input | 1 | Parity or framing error on this character |
| byte_valid | output | 1 | Decoded byte present on byte_data |
| byte_data | output | 8 | Decoded byte |
| byte_last | output | 1 | Marks the final payload byte of the frame |
| frame_done | output | 1 | Frame closed (one-cycle pulse) |
| frame_good | output | 1 | Verdict qualifying frame_done: high when the frame passed every check |

## Verification
Several properties are checked on every cycle. The byte counter never passes two, and a completed nibble pair always closes the half-byte flag. A colon always clears the sum and reopens the body state, and any frame end returns the block to idle. byte_last never appears without byte_valid, and frame_good never appears without frame_done. A done pulse is only issued for a frame whose address was accepted. The values themselves can only be shown by the bench's scenarios: the decoded byte order, the withheld check byte, the sum verdict for correct and corrupted check bytes, and the handling of lower-case, skipped, odd-length, error-marked, restarted and foreign-address frames.

// File: rtl/ascii_rx_pkg.sv
package ascii_rx_pkg;
  localparam int CHAR_W = 7;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int CNT_W  = 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BODY = 2'd1,
    RX_EOL  = 2'd2
  } rx_state_e;

  // {is_hex, nibble}; letters of both cases map onto 10..15
  function automatic logic [NIB_W:0] hex_decode(input logic [CHAR_W-1:0] c);
    if (c >= 7'h30 && c <= 7'h39) return {1'b1, c[NIB_W-1:0]};
    if (c >= 7'h41 && c <= 7'h46) return {1'b1, c[NIB_W-1:0] + 4'd9};
    if (c >= 7'h61 && c <= 7'h66) return {1'b1, c[NIB_W-1:0] + 4'd9};
    return '0;
  endfunction

  // running check: plain modulo-256 addition
  function automatic logic [BYTE_W-1:0] lrc_accum(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return acc + b;
  endfunction
endpackage

// File: rtl/ascii_char_class.sv
module ascii_char_class
  import ascii_rx_pkg::*;
#(
  parameter logic [CHAR_W-1:0] SOF_CH = 7'h3A,
  parameter logic [CHAR_W-1:0] CR_CH  = 7'h0D,
  parameter logic [CHAR_W-1:0] LF_CH  = 7'h0A
) (
  input  logic [CHAR_W-1:0] ch,
  output logic              is_sof,
  output logic              is_cr,
  output logic              is_lf,
  output logic              is_hex,
  output logic [NIB_W-1:0]  nib
);
  logic [NIB_W:0] dec;

  always_comb begin
    dec    = hex_decode(ch);
    is_hex = dec[NIB_W];
    nib    = dec[NIB_W-1:0];
    is_sof = (ch == SOF_CH);
    is_cr  = (ch == CR_CH);
    is_lf  = (ch == LF_CH);
  end
endmodule

// File: rtl/ascii_byte_pack.sv
module ascii_byte_pack
  import ascii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              nib_valid,
  input  logic [NIB_W-1:0]  nib,
  output logic              new_byte,
  output logic [BYTE_W-1:0] new_val,
  output logic              half,
  output logic [BYTE_W-1:0] sum,
  output logic [BYTE_W-1:0] hold_a,
  output logic [BYTE_W-1:0] hold_b,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2);

  logic [NIB_W-1:0] hi_nib;

  assign new_byte = nib_valid & half & ~clr;
  assign new_val  = {hi_nib, nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_nib <= '0;
      half   <= 1'b0;
      sum    <= '0;
      hold_a <= '0;
      hold_b <= '0;
      cnt    <= '0;
    end else if (clr) begin
      half   <= 1'b0;
      sum    <= '0;
      hold_a <= '0;
      hold_b <= '0;
      cnt    <= '0;
    end else if (nib_valid) begin
      if (!half) begin
        hi_nib <= nib;
        half   <= 1'b1;
      end else begin
        half   <= 1'b0;
        sum    <= lrc_accum(sum, new_val);
        hold_a <= hold_b;
        hold_b <= new_val;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
  assert_pair_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    new_byte |=> !half);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0 && cnt == '0 && !half));
endmodule

// File: rtl/ascii_frame_rx.sv
module ascii_frame_rx
  import ascii_rx_pkg::*;
#(
  parameter logic [CHAR_W-1:0] SOF_CH = 7'h3A,
  parameter logic [CHAR_W-1:0] CR_CH  = 7'h0D,
  parameter logic [CHAR_W-1:0] LF_CH  = 7'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_err,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_last,
  output logic              frame_done,
  output logic              frame_good
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2);

  rx_state_e         state;
  logic              err_q, addr_ok_q;
  logic              is_sof, is_cr, is_lf, is_hex;
  logic [NIB_W-1:0]  nib;
  logic              new_byte, half;
  logic [BYTE_W-1:0] new_val, sum, hold_a, hold_b;
  logic [CNT_W-1:0]  cnt;

  // named events for the control path and the assertions
  logic clean, evt_sof, clr, nib_valid, emit_mid, emit_last;
  logic end_lf, end_other, frame_end, report, verdict_ok, addr_hit;

  ascii_char_class #(.SOF_CH(SOF_CH), .CR_CH(CR_CH), .LF_CH(LF_CH)) u_class (
    .ch(char_data), .is_sof(is_sof), .is_cr(is_cr), .is_lf(is_lf),
    .is_hex(is_hex), .nib(nib)
  );

  ascii_byte_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .nib_valid(nib_valid), .nib(nib),
    .new_byte(new_byte), .new_val(new_val), .half(half), .sum(sum),
    .hold_a(hold_a), .hold_b(hold_b), .cnt(cnt)
  );

  always_comb begin
    clean      = char_valid & ~char_err;
    evt_sof    = clean & is_sof;
    clr        = evt_sof;
    nib_valid  = clean & is_hex & (state == RX_BODY);
    emit_mid   = new_byte & (cnt == FULL) & addr_ok_q;
    emit_last  = clean & is_cr & (state == RX_BODY) & (cnt == FULL) & addr_ok_q;
    end_lf     = clean & is_lf & (state == RX_EOL);
    end_other  = clean & ~is_lf & ~is_sof & (state == RX_EOL);
    frame_end  = end_lf | end_other;
    report     = frame_end & addr_ok_q;
    verdict_ok = end_lf & ~err_q & ~half & (cnt == FULL) & (sum == '0);
    addr_hit   = (new_val == '0) | (new_val == own_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      err_q     <= 1'b0;
      addr_ok_q <= 1'b0;
    end else begin
      if (evt_sof) begin
        state     <= RX_BODY;
        err_q     <= 1'b0;
        addr_ok_q <= 1'b0;
      end else begin
        if (char_valid && char_err && state != RX_IDLE) err_q <= 1'b1;
        if (new_byte && cnt == '0) addr_ok_q <= addr_hit;
        if (state == RX_BODY && clean && is_cr) state <= RX_EOL;
        if (frame_end) state <= RX_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_last  <= 1'b0;
      frame_done <= 1'b0;
      frame_good <= 1'b0;
    end else begin
      byte_valid <= emit_mid | emit_last;
      byte_last  <= emit_last;
      if (emit_mid | emit_last) byte_data <= hold_a;
      frame_done <= report;
      frame_good <= report & verdict_ok;
    end
  end

  assert_last_in_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> byte_valid);
  assert_good_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> frame_done);
  assert_done_no_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && byte_valid));
  assert_done_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(addr_ok_q));
  assert_sof_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sof |=> (state == RX_BODY));
  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == RX_IDLE));
endmodule

// File: tb/sim_ascii_frame_rx.sv
`timescale 1ns/1ps
module sim_ascii_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] own_addr = 8'h02;
  logic       char_valid = 1'b0;
  logic [6:0] char_data = '0;
  logic       char_err = 1'b0;
  logic       byte_valid, byte_last, frame_done, frame_good;
  logic [7:0] byte_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ascii_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .char_valid(char_valid),
    .char_data(char_data), .char_err(char_err), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_last(byte_last), .frame_done(frame_done),
    .frame_good(frame_good)
  );

  typedef struct packed {
    logic [255:0] txt;
    logic [7:0]   own;
    logic [47:0]  bytes;
    logic [3:0]   nb;
    logic         done;
    logic         good;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{":020100000008F5\r\n",       8'h02, 48'h020100000008, 4'd6, 1'b1, 1'b1}, // R3 good
    '{":000612340001b3\r\n",       8'h02, 48'h000612340001, 4'd6, 1'b1, 1'b1}, // R6 broadcast, R2 lower case
    '{":1103006b00037E\r\n",       8'h11, 48'h1103006B0003, 4'd6, 1'b1, 1'b1}, // R2 mixed case
    '{":020100000008F4\r\n",       8'h02, 48'h020100000008, 4'd6, 1'b1, 1'b0}, // R3 bad check
    '{":050300010001F6\r\n",       8'h02, 48'h000000000000, 4'd0, 1'b0, 1'b0}, // R6 foreign address
    '{":020100000008F5A\r\n",      8'h02, 48'h020100000008, 4'd6, 1'b1, 1'b0}, // R9 odd count
    '{":0301:020100000008F5\r\n",  8'h02, 48'h020100000008, 4'd6, 1'b1, 1'b1}, // R8 restart
    '{":02 01-00000008F5\r\n",     8'h02, 48'h020100000008, 4'd6, 1'b1, 1'b1}  // R2 skipped chars
  };

  // output monitor
  logic [7:0] rx_buf [16];
  int rx_n = 0, last_n = 0, last_pos = -1, done_n = 0;
  logic good_seen = 1'b0;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (rx_n < 16) rx_buf[rx_n] = byte_data;
      if (byte_last) begin
        last_n++;
        last_pos = rx_n;
      end
      rx_n++;
    end
    if (frame_done) begin
      done_n++;
      good_seen = frame_good;
    end
  end

  task automatic mon_clear();
    rx_n = 0; last_n = 0; last_pos = -1; done_n = 0; good_seen = 1'b0;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] c, input logic e);
    @(negedge clk);
    char_valid = 1'b1; char_data = c; char_err = e;
    @(negedge clk);
    char_valid = 1'b0; char_err = 1'b0;
  endtask

  task automatic send_txt(input logic [255:0] t);
    for (int k = 31; k >= 0; k--)
      if (t[k*8 +: 8] != 8'h00) send(t[k*8 +: 7], 1'b0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 byte_valid after reset", byte_valid, 0);
    chk("R12 byte_last after reset", byte_last, 0);
    chk("R12 frame_done after reset", frame_done, 0);
    chk("R12 frame_good after reset", frame_good, 0);
    rst_n = 1'b1;
    settle();

    // table walk
    for (int i = 0; i < 8; i++) begin
      own_addr = VECS[i].own;
      mon_clear();
      send_txt(VECS[i].txt);
      settle();
      chk($sformatf("R5 byte count vec%0d", i), rx_n, VECS[i].nb);
      for (int j = 0; j < int'(VECS[i].nb); j++)
        chk($sformatf("R2 byte %0d vec%0d", j, i), rx_buf[j], VECS[i].bytes[47-8*j -: 8]);
      chk($sformatf("R5 last flags vec%0d", i), last_n, (VECS[i].nb != 0) ? 1 : 0);
      if (VECS[i].nb != 0)
        chk($sformatf("R5 last position vec%0d", i), last_pos, VECS[i].nb - 1);
      chk($sformatf("R4 R6 done count vec%0d", i), done_n, VECS[i].done);
      if (VECS[i].done)
        chk($sformatf("R3 verdict vec%0d", i), good_seen, VECS[i].good);
    end

    // R1: characters outside a frame are ignored
    own_addr = 8'h02;
    mon_clear();
    send_txt("0201F5\r\n");
    send(7'h30, 1'b1);
    settle();
    chk("R1 idle bytes", rx_n, 0);
    chk("R1 idle done", done_n, 0);

    // R4 and R5 exact cycle of byte_last and frame_done
    mon_clear();
    send_txt(":020100000008F5");
    send(7'h0D, 1'b0);
    chk("R5 byte_last one cycle after CR", byte_last, 1);
    chk("R5 last byte value", byte_data, 8'h08);
    send(7'h0A, 1'b0);
    chk("R4 frame_done one cycle after LF", frame_done, 1);
    chk("R4 frame_good with done", frame_good, 1);
    @(negedge clk);
    chk("R4 frame_done single pulse", frame_done, 0);

    // R7: error-marked character inside a frame
    mon_clear();
    send_txt(":020100");
    send(7'h5A, 1'b1);
    send_txt("000008F5\r\n");
    settle();
    chk("R7 done count", done_n, 1);
    chk("R7 verdict bad", good_seen, 0);

    // R10: one byte only
    mon_clear();
    send_txt(":02\r\n");
    settle();
    chk("R10 bytes", rx_n, 0);
    chk("R10 done count", done_n, 1);
    chk("R10 verdict bad", good_seen, 0);

    // R6: no byte at all is dropped silently
    mon_clear();
    send_txt(":\r\n");
    settle();
    chk("R6 empty frame done", done_n, 0);

    // R11: unexpected character after CR
    mon_clear();
    send_txt(":020100000008F5\r");
    send(7'h58, 1'b0);
    chk("R11 immediate done", frame_done, 1);
    chk("R11 verdict bad", frame_good, 0);
    settle();
    mon_clear();
    send(7'h0A, 1'b0);
    settle();
    chk("R11 LF after abort ignored", done_n, 0);

    // R8: colon after CR restarts too
    mon_clear();
    send_txt(":0301\r:020100000008F5\r\n");
    settle();
    chk("R8 restart after CR bytes", rx_n, 6);
    chk("R8 restart after CR verdict", good_seen, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule